// File: doc/BRIEF.md
# Handshake Byte Transfer Engine

This block carries packet bytes between a host processor and a device-side byte store, one byte for each handshake step. The host drives two active-low lines, "transfer active" and "acknowledge", by writing a port register. The block drives a third active-low line, "request", inside the same register. Each byte passes through a one-byte shift register. A direction bit in a control register selects whether the host is sending bytes (they are appended to an outbound buffer) or receiving them (they are loaded from an inbound buffer).

Bytes advance when the handshake lines change, not on a shift clock. After most handshake events the block raises a one-cycle shift interrupt. The interrupt comes after a programmable delay, or at once when the port direction register holds all ones. When the host ends a transfer that carried outbound bytes, the block emits a packet-complete pulse with the byte count. The collected bytes can then be read from a synchronous read port. The device side fills the inbound buffer through a write port and starts an inbound packet with a load strobe and a length.

Top module: `hs_byte_xfer`

## Requirements
- R1: After reset the port register reads 0x38 (all three lines deasserted), the shift register reads 0, the port direction register holds 0xFF, the control register holds 0, and neither `sr_irq` nor `pkt_valid` is high.
- R2: The port register uses bit 5 for transfer active, bit 4 for acknowledge and bit 3 for request, all active low. Register selects are 0 = port, 1 = port direction, 2 = shift register, 3 = control. The block alone drives bit 3, so the bit-3 value in a host write has no effect on `portb_q`. All other bits are stored as written.
- R3: When control bit 4 is 1 (host to device) and a port write keeps bit 5 low while changing bit 5 or bit 4 from the stored value, the shift byte is appended to the outbound buffer and a shift interrupt is scheduled.
- R4: When control bit 4 is 0 (device to host), the same kind of write loads the next unread inbound byte into the shift register and schedules an interrupt. When that byte is the last one, bit 3 is driven high. With no unread bytes, such a write has no effect.
- R5: When a port write leaves bit 5 high and bit 5 was already high, a change in bit 4 is copied onto bit 3, and an interrupt is scheduled.
- R6: A port write that raises bit 5 from low always schedules an interrupt. If outbound bytes were collected, `pkt_valid` is high for one cycle after the write with `pkt_len` equal to the count, and the outbound count returns to zero. `out_rd_data` shows buffer entry `out_rd_addr` one cycle after the address is applied.
- R7: A port write that leaves bit 5 high without taking the R5 path drives bit 3 low when unread inbound bytes remain.
- R8: An outbound byte that arrives when the buffer already holds DEPTH bytes is dropped and schedules no interrupt. The packet length then stays at DEPTH.
- R9: A scheduled interrupt pulses `sr_irq` IRQ_DELAY cycles after the scheduling edge. Scheduling again restarts the wait. When the port direction register is 0xFF, the pulse comes in the cycle right after the scheduling edge.
- R10: `in_start` sets the inbound index to 0 and sets the inbound length to `in_len`, clamped to DEPTH. If bit 5 is high and the length is nonzero, it drives bit 3 low. It schedules an interrupt. A register write in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 port, 1 port direction, 2 shift, 3 control) |
| reg_wdata | input | 8 | Register write data |
| in_wr_en | input | 1 | Inbound buffer write enable |
| in_wr_addr | input | AW | Inbound buffer write address |
| in_wr_data | input | 8 | Inbound buffer write data |
| in_start | input | 1 | Start a new inbound packet |
| in_len | input | IW | Inbound packet length |
| out_rd_addr | input | AW | Outbound buffer read address |
| out_rd_data | output | 8 | Outbound buffer data, one cycle latency |
| portb_q | output | 8 | Port register with request bit |
| shift_q | output | 8 | Shift register byte |
| sr_irq | output | 1 | One-cycle shift interrupt pulse |
| pkt_valid | output | 1 | Outbound packet complete pulse |
| pkt_len | output | IW | Byte count of completed outbound packet |

## Verification
On every cycle, the assertions check that the outbound count never exceeds the buffer depth and that each packet pulse carries a nonzero length with the count already cleared. They also check that loading the final inbound byte leaves request high and that a pending delayed interrupt never has a zero counter. The timing of the interrupt and its restart, the routing of bytes in each direction, the clamp and the drop of extra bytes are shown only by the bench scenarios. The same holds for the request line in idle and pending states, and for the precedence of a packet load over a register write.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  localparam logic [1:0] SEL_PORT  = 2'd0;
  localparam logic [1:0] SEL_PDIR  = 2'd1;
  localparam logic [1:0] SEL_SHIFT = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;
  localparam int BIT_REQ    = 3;
  localparam int BIT_ACK    = 4;
  localparam int BIT_ACTIVE = 5;
  localparam int BIT_DIR    = 4;
endpackage

// File: rtl/hsx_irq_delay.sv
module hsx_irq_delay #(
  parameter int IRQ_DELAY = 75000
) (
  input  logic clk,
  input  logic rst,
  input  logic sched,
  input  logic immediate,
  output logic irq
);
  localparam int CW = $clog2(IRQ_DELAY + 1);
  logic [CW-1:0] cnt;
  logic          pend;
  logic          arm;

  assign arm = sched && !immediate;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= (sched && immediate) || (pend && cnt == CW'(1) && !arm);
      if (arm) begin
        cnt  <= CW'(IRQ_DELAY);
        pend <= 1'b1;
      end else if (pend) begin
        if (cnt == CW'(1)) pend <= 1'b0;
        else cnt <= cnt - CW'(1);
      end
    end
  end

  // R9: a waiting interrupt always has time left
  assert_pending_count_R9: assert property (@(posedge clk) disable iff (rst)
    pend |-> cnt != '0) else $error("pending interrupt with zero count");
endmodule

// File: rtl/hsx_outbuf.sv
module hsx_outbuf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hsx_inbuf.sv
module hsx_inbuf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/hs_byte_xfer.sv
module hs_byte_xfer
  import hsx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int IRQ_DELAY = 75000,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          in_wr_en,
  input  logic [AW-1:0] in_wr_addr,
  input  logic [7:0]    in_wr_data,
  input  logic          in_start,
  input  logic [IW-1:0] in_len,
  input  logic [AW-1:0] out_rd_addr,
  output logic [7:0]    out_rd_data,
  output logic [7:0]    portb_q,
  output logic [7:0]    shift_q,
  output logic          sr_irq,
  output logic          pkt_valid,
  output logic [IW-1:0] pkt_len
);
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  logic [7:0]    pdir_q;
  logic          dir_out_q;
  logic [IW-1:0] in_idx, in_cnt, out_idx;
  logic [7:0]    in_rd_data;

  logic          port_wr;
  logic [7:0]    nb;
  logic          req_n, sched, out_we, pkt_n;
  logic [IW-1:0] in_idx_n, in_cnt_n, out_idx_n;
  logic [7:0]    sr_n;
  logic [IW-1:0] len_clamped;

  assign port_wr     = reg_we && !in_start && reg_sel == SEL_PORT;
  assign len_clamped = (in_len > DEPTH_W) ? DEPTH_W : in_len;

  always_comb begin
    nb        = {reg_wdata[7:4], portb_q[BIT_REQ], reg_wdata[2:0]};
    req_n     = portb_q[BIT_REQ];
    in_idx_n  = in_idx;
    in_cnt_n  = in_cnt;
    out_idx_n = out_idx;
    sr_n      = shift_q;
    sched     = 1'b0;
    out_we    = 1'b0;
    pkt_n     = 1'b0;
    if (in_start) begin
      in_idx_n = '0;
      in_cnt_n = len_clamped;
      if (portb_q[BIT_ACTIVE] && len_clamped != '0) req_n = 1'b0;
      sched = 1'b1;
    end else if (port_wr) begin
      if (!nb[BIT_ACTIVE]) begin
        if (nb[BIT_ACTIVE:BIT_ACK] != portb_q[BIT_ACTIVE:BIT_ACK]) begin
          if (dir_out_q) begin
            if (out_idx < DEPTH_W) begin
              out_we    = 1'b1;
              out_idx_n = out_idx + IW'(1);
              sched     = 1'b1;
            end
          end else if (in_idx < in_cnt) begin
            sr_n     = in_rd_data;
            in_idx_n = in_idx + IW'(1);
            if (in_idx + IW'(1) == in_cnt) req_n = 1'b1;
            sched    = 1'b1;
          end
        end
      end else if (portb_q[BIT_ACTIVE] && nb[BIT_ACK] != portb_q[BIT_ACK]) begin
        req_n = nb[BIT_ACK];
        sched = 1'b1;
      end else begin
        if (!portb_q[BIT_ACTIVE]) begin
          sched = 1'b1;
          if (out_idx != '0) begin
            pkt_n     = 1'b1;
            out_idx_n = '0;
          end
        end
        if (in_idx < in_cnt) req_n = 1'b0;
      end
    end else if (reg_we && !in_start && reg_sel == SEL_SHIFT) begin
      sr_n = reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      portb_q   <= 8'h38;
      pdir_q    <= 8'hFF;
      dir_out_q <= 1'b0;
      shift_q   <= 8'h00;
      in_idx    <= '0;
      in_cnt    <= '0;
      out_idx   <= '0;
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
    end else begin
      if (port_wr) portb_q <= {nb[7:4], req_n, nb[2:0]};
      else         portb_q[BIT_REQ] <= req_n;
      if (reg_we && !in_start && reg_sel == SEL_PDIR) pdir_q <= reg_wdata;
      if (reg_we && !in_start && reg_sel == SEL_CTRL) dir_out_q <= reg_wdata[BIT_DIR];
      shift_q   <= sr_n;
      in_idx    <= in_idx_n;
      in_cnt    <= in_cnt_n;
      out_idx   <= out_idx_n;
      pkt_valid <= pkt_n;
      if (pkt_n) pkt_len <= out_idx;
    end
  end

  hsx_outbuf #(.DEPTH(DEPTH)) u_outbuf (
    .clk(clk), .we(out_we), .waddr(out_idx[AW-1:0]), .wdata(shift_q),
    .raddr(out_rd_addr), .rdata(out_rd_data));

  hsx_inbuf #(.DEPTH(DEPTH)) u_inbuf (
    .clk(clk), .we(in_wr_en), .waddr(in_wr_addr), .wdata(in_wr_data),
    .raddr(in_idx[AW-1:0]), .rdata(in_rd_data));

  hsx_irq_delay #(.IRQ_DELAY(IRQ_DELAY)) u_irq (
    .clk(clk), .rst(rst), .sched(sched), .immediate(pdir_q == 8'hFF),
    .irq(sr_irq));

  // R8: the outbound count never passes the buffer depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    out_idx <= DEPTH_W) else $error("outbound count beyond depth");

  // R6: a packet pulse carries a length and a cleared count
  assert_pkt_len_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_len != '0 && out_idx == '0)) else $error("bad packet pulse");

  // R4: taking the last inbound byte leaves request deasserted
  assert_last_byte_req_R4: assert property (@(posedge clk) disable iff (rst)
    (in_cnt != '0 && in_idx == in_cnt && in_idx != $past(in_idx)) |-> portb_q[BIT_REQ])
    else $error("request low after last inbound byte");

  // R10: the inbound index never runs past the packet length
  assert_in_idx_bound_R10: assert property (@(posedge clk) disable iff (rst)
    in_idx <= in_cnt) else $error("inbound index beyond length");
endmodule

// File: tb/test_hs_byte_xfer.sv
`timescale 1ns/1ps
module test_hs_byte_xfer;
  localparam int DEPTH = 4;
  localparam int DLY   = 8;
  localparam int AW    = 2;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic in_wr_en = 1'b0;
  logic [AW-1:0] in_wr_addr = '0;
  logic [7:0] in_wr_data = '0;
  logic in_start = 1'b0;
  logic [IW-1:0] in_len = '0;
  logic [AW-1:0] out_rd_addr = '0;
  logic [7:0] out_rd_data, portb_q, shift_q;
  logic sr_irq, pkt_valid;
  logic [IW-1:0] pkt_len;

  int n_checks = 0;
  int n_fail = 0;
  int irq_cnt = 0;

  always #2 clk = ~clk;

  hs_byte_xfer #(.DEPTH(DEPTH), .IRQ_DELAY(DLY)) i_hs_byte_xfer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data),
    .in_start(in_start), .in_len(in_len), .out_rd_addr(out_rd_addr),
    .out_rd_data(out_rd_data), .portb_q(portb_q), .shift_q(shift_q),
    .sr_irq(sr_irq), .pkt_valid(pkt_valid), .pkt_len(pkt_len));

  always @(negedge clk) if (!rst && sr_irq) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 port", portb_q, 8'h38);
    chk("R1 shift", shift_q, 0);
    chk("R1 irq", sr_irq, 0);
    chk("R1 pkt", pkt_valid, 0);
  endtask

  task automatic t_bit3_ignored();
    wr(2'd0, 8'h30);
    chk("R2 req bit held", portb_q, 8'h38);
    wr(2'd0, 8'h3F);
    chk("R2 low bits stored", portb_q, 8'h3F);
    wr(2'd0, 8'h38);
  endtask

  task automatic t_idle_mirror();
    int c0 = irq_cnt;
    wr(2'd0, 8'h28);
    chk("R5 req follows ack low", portb_q, 8'h20);
    chk("R5 irq immediate", irq_cnt, c0 + 1);
    wr(2'd0, 8'h30);
    chk("R5 req follows ack high", portb_q, 8'h38);
  endtask

  task automatic t_delay();
    int c0;
    wr(2'd1, 8'h00);
    c0 = irq_cnt;
    wr(2'd0, 8'h20);
    wait_cyc(DLY - 1);
    chk("R9 no early irq", irq_cnt, c0);
    wait_cyc(1);
    chk("R9 irq after delay", irq_cnt, c0 + 1);
    c0 = irq_cnt;
    wr(2'd0, 8'h30);
    wait_cyc(3);
    wr(2'd0, 8'h20);
    wait_cyc(DLY - 1);
    chk("R9 restart suppresses first", irq_cnt, c0);
    wait_cyc(1);
    chk("R9 single irq after restart", irq_cnt, c0 + 1);
    wr(2'd0, 8'h30);
    wait_cyc(DLY + 2);
    wr(2'd1, 8'hFF);
  endtask

  task automatic t_outbound();
    int c0;
    wr(2'd3, 8'h10);
    c0 = irq_cnt;
    wr(2'd2, 8'hA1);
    wr(2'd0, 8'h10);
    chk("R3 irq byte0", irq_cnt, c0 + 1);
    wr(2'd2, 8'hB2);
    wr(2'd0, 8'h00);
    chk("R3 irq byte1", irq_cnt, c0 + 2);
    wr(2'd0, 8'h20);
    chk("R6 pkt pulse", pkt_valid, 1);
    chk("R6 pkt len", pkt_len, 2);
    chk("R6 end irq", irq_cnt, c0 + 3);
    wait_cyc(1);
    chk("R6 pulse one cycle", pkt_valid, 0);
    out_rd_addr = 2'd0; wait_cyc(1);
    chk("R3 buffer byte0", out_rd_data, 8'hA1);
    out_rd_addr = 2'd1; wait_cyc(1);
    chk("R3 buffer byte1", out_rd_data, 8'hB2);
    wr(2'd0, 8'h30);
  endtask

  task automatic t_overflow();
    int c0 = irq_cnt;
    for (int i = 0; i < 6; i++) begin
      wr(2'd2, 8'h40 + 8'(i));
      wr(2'd0, (i % 2 == 0) ? 8'h10 : 8'h00);
    end
    chk("R8 extra bytes no irq", irq_cnt, c0 + 4);
    wr(2'd0, 8'h30);
    chk("R8 len capped", pkt_len, DEPTH);
    chk("R8 pkt pulse", pkt_valid, 1);
    out_rd_addr = 2'd3; wait_cyc(1);
    chk("R8 last kept byte", out_rd_data, 8'h43);
  endtask

  task automatic t_inbound();
    int c0;
    wr(2'd3, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      in_wr_en = 1'b1; in_wr_addr = AW'(i); in_wr_data = 8'hC0 + 8'(i);
    end
    @(negedge clk);
    in_wr_en = 1'b0;
    c0 = irq_cnt;
    @(negedge clk);
    in_start = 1'b1; in_len = 3'd6;
    @(negedge clk);
    in_start = 1'b0;
    #1;
    chk("R10 load irq", irq_cnt, c0 + 1);
    chk("R7 req low pending", portb_q[3], 0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(2'd0, (i % 2 == 0) ? 8'h10 : 8'h00);
      chk("R4 shift byte", shift_q, 8'hC0 + i);
      chk("R4 req level", portb_q[3], (i == DEPTH - 1) ? 1 : 0);
    end
    c0 = irq_cnt;
    wr(2'd0, 8'h10);
    chk("R10 clamp no fifth byte", shift_q, 8'hC3);
    chk("R4 no irq when empty", irq_cnt, c0);
    wr(2'd0, 8'h30);
    chk("R6 no pkt inbound", pkt_valid, 0);
    chk("R7 req stays high", portb_q[3], 1);
  endtask

  task automatic t_priority();
    int c0 = irq_cnt;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h00;
    in_start = 1'b1; in_len = 3'd0;
    @(negedge clk);
    reg_we = 1'b0; in_start = 1'b0;
    #1;
    chk("R10 write ignored", portb_q, 8'h38);
    chk("R10 load schedules irq", irq_cnt, c0 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_bit3_ignored();
    t_idle_mirror();
    t_delay();
    t_outbound();
    t_overflow();
    t_inbound();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule